// File: doc/BRIEF.md
# Asymmetric push-button debouncer

This block turns the raw level of one mechanical push button into a clean level. The raw input is not assumed to be related to the clock, so it first passes through a two-flop synchroniser. A small state machine and one hold counter then remove the contact bounce. Only one edge of the output is filtered. The other edge follows the synchronised input with no added wait.

The parameter `MODE` picks which edge is filtered. With `MODE = 0` the output rises on the first high level it sees, even in the middle of a bounce. It falls only after the input has stayed low for the full hold time. With `MODE = 1` the roles swap: the rise waits for a steady high input and the fall is immediate. `HOLD_BITS` is the width of the hold counter. Choose it from the worst bounce time measured on the button and the clock rate: the hold time is 2^HOLD_BITS clock cycles.

The state machine has four states:
- `S_OFF`: output low, input low.
- `S_ON`: output high, input high.
- `S_ARMING`: output low, waiting for the input to stay high.
- `S_DRAINING`: output high, waiting for the input to stay low.

Its transitions, named by the input event that triggers them:
- **press**: `S_OFF` goes to `S_ON` in mode 0, or to `S_ARMING` in mode 1.
- **release**: `S_ON` goes to `S_DRAINING` in mode 0, or to `S_OFF` in mode 1.
- **abort-arm**: input drops while in `S_ARMING`, back to `S_OFF`.
- **abort-drain**: input rises while in `S_DRAINING`, back to `S_ON`.
- **armed**: hold counter at its terminal value, `S_ARMING` goes to `S_ON`.
- **drained**: hold counter at its terminal value, `S_DRAINING` goes to `S_OFF`.

The counter runs only in a waiting state while the input holds the awaited level. It clears whenever the state machine leaves a waiting state.

Top module: `press_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the output is low after that edge and the hold counter is cleared.
- R2: The raw input passes through two synchronising flops. An immediate output change appears after the third rising clock edge following the input change, and not after the second.
- R3: In mode 0, the output rises after the third edge following the first high level of the input. This holds even if the input then bounces, and even for a high pulse of a single cycle.
- R4: In mode 0, after the input goes low and stays low, the output stays high through the 18th edge. It goes low after the (3 + 2^HOLD_BITS)-th edge; with HOLD_BITS = 4 that is the 19th edge.
- R5: In mode 0, a high level seen while draining cancels the wait. The full hold time is counted again from the last falling edge of the input.
- R6: In mode 1, the output rises only after the input has been high without a break. It rises after the (3 + 2^HOLD_BITS)-th edge following the final rising edge of the input. A short high pulse leaves the output low.
- R7: In mode 1, the output falls after the third edge following the input going low.
- R8: In mode 1, a low level seen while arming cancels the wait. The full hold time is counted again from the last rising edge of the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw button level, asynchronous to the clock |
| btn_clean | output | 1 | Debounced button level |

## Verification
The checker watches four rules on every cycle:
- the fast edge follows one cycle after the synchronised level;
- the slow edge never moves unless the hold counter is at its terminal value;
- the terminal value never lasts two cycles in a row;
- reset leaves the output low and the counter clear.

Only the bench scenarios can show the exact latencies measured from the raw pin: the 3-edge immediate path and the 3 + 2^HOLD_BITS-edge delayed path. Only they can show that a mid-wait bounce restarts the full hold time, and that a one-cycle glitch gives a full-length output pulse in mode 0 but no pulse in mode 1.

// File: rtl/press_filter_pkg.sv
package press_filter_pkg;

    // Debouncer state; the output is high in S_ON and S_DRAINING
    typedef enum logic [1:0] {
        S_OFF      = 2'd0,
        S_ON       = 2'd1,
        S_ARMING   = 2'd2,
        S_DRAINING = 2'd3
    } pf_state_t;

    // MODE values
    localparam int MODE_FAST_RISE = 0;
    localparam int MODE_FAST_FALL = 1;

endpackage

// File: rtl/press_sync.sv
module press_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/press_hold_cnt.sv
module press_hold_cnt #(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);

    localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt;

    // Counts while run is high; any cycle without run restarts from zero
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign done = (cnt == TERMINAL);

endmodule

// File: rtl/press_fsm.sv
module press_fsm
    import press_filter_pkg::*;
#(
    parameter int MODE = MODE_FAST_RISE
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic hold_done,
    output logic hold_run,
    output logic out_lvl
);

    localparam bool_fast_rise = (MODE == MODE_FAST_RISE);

    pf_state_t state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF: begin
                if (lvl) begin
                    state_nx = bool_fast_rise ? S_ON : S_ARMING;      // press
                end
            end
            S_ON: begin
                if (!lvl) begin
                    state_nx = bool_fast_rise ? S_DRAINING : S_OFF;   // release
                end
            end
            S_ARMING: begin
                if (!lvl) begin
                    state_nx = S_OFF;                                 // abort-arm
                end else if (hold_done) begin
                    state_nx = S_ON;                                  // armed
                end
            end
            S_DRAINING: begin
                if (lvl) begin
                    state_nx = S_ON;                                  // abort-drain
                end else if (hold_done) begin
                    state_nx = S_OFF;                                 // drained
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        out_lvl  = 1'b0;
        hold_run = 1'b0;
        unique case (state)
            S_OFF:      out_lvl = 1'b0;
            S_ON:       out_lvl = 1'b1;
            S_ARMING: begin
                out_lvl  = 1'b0;
                hold_run = lvl && !hold_done;
            end
            S_DRAINING: begin
                out_lvl  = 1'b1;
                hold_run = !lvl && !hold_done;
            end
        endcase
    end

endmodule

// File: rtl/press_filter.sv
module press_filter
    import press_filter_pkg::*;
#(
    parameter int HOLD_BITS   = 16,
    parameter int MODE        = MODE_FAST_RISE,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic btn_clean
);

    logic sync_lvl;
    logic hold_run;
    logic hold_done;

    press_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (btn_raw),
        .q_sync  (sync_lvl)
    );

    press_hold_cnt #(.WIDTH(HOLD_BITS)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (hold_run),
        .done (hold_done)
    );

    press_fsm #(.MODE(MODE)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .lvl       (sync_lvl),
        .hold_done (hold_done),
        .hold_run  (hold_run),
        .out_lvl   (btn_clean)
    );

endmodule

// File: rtl/press_filter_chk.sv
module press_filter_chk #(
    parameter int MODE = 0
) (
    input logic clk,
    input logic rst,
    input logic sync_lvl,
    input logic done,
    input logic out_lvl
);

    // R1: reset leaves the output low and the counter away from its terminal value
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!out_lvl && !done));

    // R5, R8: the terminal value never lasts two cycles, so a wait always ends or restarts
    a_r5_r8_no_stuck_terminal: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    generate
        if (MODE == 0) begin : g_fast_rise
            // R3: a high synchronised level with output low raises the output next cycle
            a_r3_fast_rise: assert property (@(posedge clk) disable iff (rst)
                (!out_lvl && sync_lvl) |=> out_lvl);
            // R4: the output leaves high only when the hold counter has finished
            a_r4_slow_fall: assert property (@(posedge clk) disable iff (rst)
                (out_lvl && !done) |=> out_lvl);
        end else begin : g_fast_fall
            // R7: a low synchronised level with output high drops the output next cycle
            a_r7_fast_fall: assert property (@(posedge clk) disable iff (rst)
                (out_lvl && !sync_lvl) |=> !out_lvl);
            // R6: the output leaves low only when the hold counter has finished
            a_r6_slow_rise: assert property (@(posedge clk) disable iff (rst)
                (!out_lvl && !done) |=> !out_lvl);
        end
    endgenerate

endmodule

bind press_filter press_filter_chk #(.MODE(MODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_lvl (sync_lvl),
    .done     (hold_done),
    .out_lvl  (btn_clean)
);

// File: tb/sim_press_filter.sv
`timescale 1ns/1ps
module sim_press_filter;

    localparam int HB = 4;           // hold time 16 cycles
    localparam int SLOW = 3 + (1 << HB);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw0 = 1'b0;
    logic raw1 = 1'b0;
    logic out0;
    logic out1;

    int vectors = 0;
    int errors  = 0;

    always #2.5 clk = ~clk;

    press_filter #(.HOLD_BITS(HB), .MODE(0)) u0 (
        .clk(clk), .rst(rst), .btn_raw(raw0), .btn_clean(out0));

    press_filter #(.HOLD_BITS(HB), .MODE(1)) u1 (
        .clk(clk), .rst(rst), .btn_raw(raw1), .btn_clean(out1));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        tick(3);
        check("R1 mode0", out0, 1'b0);
        check("R1 mode1", out1, 1'b0);
        rst = 1'b0;
        tick(20);
        check("R1 idle mode0", out0, 1'b0);
        check("R1 idle mode1", out1, 1'b0);
    endtask

    task automatic t_m0_press_release();
        raw0 = 1'b1;
        tick(2);
        check("R2 mode0 not yet", out0, 1'b0);
        tick(1);
        check("R2 R3 mode0 rise", out0, 1'b1);
        for (int i = 0; i < 6; i++) begin
            raw0 = ~raw0;
            tick(1);
            check("R3 bounce held", out0, 1'b1);
        end
        tick(30);
        check("R3 held", out0, 1'b1);
        raw0 = 1'b0;
        tick(SLOW - 1);
        check("R4 still high", out0, 1'b1);
        tick(1);
        check("R4 fall", out0, 1'b0);
        tick(20);
    endtask

    task automatic t_m0_restart();
        raw0 = 1'b1;
        tick(30);
        raw0 = 1'b0;
        tick(8);
        raw0 = 1'b1;
        tick(1);
        raw0 = 1'b0;
        tick(SLOW - 1);
        check("R5 restart high", out0, 1'b1);
        tick(1);
        check("R5 restart fall", out0, 1'b0);
        tick(20);
    endtask

    task automatic t_m0_glitch();
        raw0 = 1'b1;
        tick(1);
        raw0 = 1'b0;
        tick(2);
        check("R3 glitch rise", out0, 1'b1);
        tick(SLOW - 3);
        check("R3 glitch stretched", out0, 1'b1);
        tick(1);
        check("R3 glitch end", out0, 1'b0);
        tick(20);
    endtask

    task automatic t_m1_press();
        for (int i = 0; i < 4; i++) begin
            raw1 = ~raw1;
            tick(1);
            check("R6 bounce low", out1, 1'b0);
        end
        raw1 = 1'b1;
        tick(SLOW - 1);
        check("R6 still low", out1, 1'b0);
        tick(1);
        check("R6 rise", out1, 1'b1);
        tick(10);
    endtask

    task automatic t_m1_release();
        raw1 = 1'b0;
        tick(2);
        check("R2 mode1 not yet", out1, 1'b1);
        tick(1);
        check("R7 fall", out1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            raw1 = ~raw1;
            tick(1);
        end
        tick(5);
        check("R7 release bounce low", out1, 1'b0);
        tick(20);
    endtask

    task automatic t_m1_restart();
        raw1 = 1'b1;
        tick(10);
        raw1 = 1'b0;
        tick(1);
        raw1 = 1'b1;
        tick(SLOW - 1);
        check("R8 restart low", out1, 1'b0);
        tick(1);
        check("R8 restart rise", out1, 1'b1);
        raw1 = 1'b0;
        tick(20);
    endtask

    task automatic t_m1_glitch();
        raw1 = 1'b1;
        tick(1);
        raw1 = 1'b0;
        for (int i = 0; i < 25; i++) begin
            tick(1);
            check("R6 glitch ignored", out1, 1'b0);
        end
    endtask

    initial begin
        tick(1);
        t_reset();
        t_m0_press_release();
        t_m0_restart();
        t_m0_glitch();
        t_m1_press();
        t_m1_release();
        t_m1_restart();
        t_m1_glitch();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #100000;
        vectors++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule